// File: doc/BRIEF.md
# Capture-Compare Timer with Toggle Output

This block is a free-running up-counter with a programmable prescaler. It can copy the running count into one of two capture registers when an external trigger pin changes. A single output flip-flop can flip on two kinds of event: the count reaching one of two compare values, or a capture. Each of these four events has its own enable bit. With these enables, software or hardware can build one-shot pulses tied to an external edge. A delayed pulse uses the two compare values as start and end. A pulse with no delay starts at the capture itself, and software then programs the end point from the capture interrupt.

Software drives the block through a simple write port. This port gives access to the run control, the clock and capture modes, the flip-flop control, the two compare values and an interrupt mask. Three interrupt request pulses are provided: one for each capture register, and a combined one for compare matches and counter wrap. The count and both capture registers are visible as outputs.

Top module: `capcmp_timer`

Register addresses on `wr_addr`: 0 run control, 1 mode, 2 flip-flop control, 3 compare 0, 4 compare 1, 5 interrupt mask.

## Requirements
- R1: The counter advances by one for every 2^(1+2*s) clock cycles, where s is mode bits [1:0]. Code 00 gives one step every 2 cycles and code 01 gives one step every 8 cycles. Counting needs both run-control bit 0 (count enable) and bit 1 (prescaler run) set.
- R2: While either run-control bit is 0, the count holds its value.
- R3: Mode bits [3:2] select the capture mode. With code 01, a rising trigger copies the count into capture 0 and a falling trigger copies it into capture 1. Each capture raises a one-cycle pulse on irq_cap0 or irq_cap1. The pulse appears at the third rising clock edge after the pin changes (two synchronizer stages, then edge detection). The captured value is the count that was present just before that edge.
- R4: With capture-mode code 00, trigger edges change neither capture register and raise no capture interrupt.
- R5: Flip-flop control bit 4 makes the output toggle on each capture into capture 0. Bit 5 does the same for capture 1.
- R6: Flip-flop control bit 2 makes the output toggle in the cycle the count steps to compare 0. Bit 3 does the same for compare 1. Compare 0 and compare 1 together give a delayed pulse whose width, in counts, is compare 1 minus compare 0.
- R7: Flip-flop control bits [1:0] act when written. Code 10 clears the output and code 01 sets it. The other codes leave the output unchanged.
- R8: The mask register has bit 0 for compare 0, bit 1 for compare 1 and bit 2 for wrap. A 1 masks that source. Any unmasked source raises a one-cycle irq_tmr pulse in the cycle it occurs. After reset, all three sources are masked.
- R9: The counter wraps from all ones to zero, and the wrap is an interrupt source.
- R10: A compare write takes effect at once. If the compare value is already below the count, no match occurs until the counter has wrapped.
- R11: After reset, the count, both capture registers, the output and all interrupt pulses are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | DATA_W | Write data |
| trig_in | input | 1 | Asynchronous external trigger |
| count | output | CNT_W | Current count |
| cap0 | output | CNT_W | Capture register 0 (rising edge) |
| cap1 | output | CNT_W | Capture register 1 (falling edge) |
| tmr_out | output | 1 | Toggle flip-flop output |
| irq_cap0 | output | 1 | Capture-0 interrupt pulse |
| irq_cap1 | output | 1 | Capture-1 interrupt pulse |
| irq_tmr | output | 1 | Compare/wrap interrupt pulse |

## Verification
The bench measures the exact cycle of a capture interrupt after a pin edge. A design with one synchronizer stage too many or too few would raise the interrupt a cycle early or late. The bench also compares the captured value with a frozen count, so a design that captured the next count would be caught.

For both one-shot forms, every output transition is scored against the count at which it occurred. A design that toggled one step late, or on the old compare value after a rewrite, would give the wrong width.

A compare value left behind the count is checked across a wrap, together with the wrap interrupt. A design that matched on "greater or equal" would fire at once. A design without a wrap event would miss the first expected interrupt.

// File: rtl/capcmp_pkg.sv
package capcmp_pkg;
  localparam logic [2:0] ADDR_CTRL  = 3'd0;
  localparam logic [2:0] ADDR_MODE  = 3'd1;
  localparam logic [2:0] ADDR_FFCTL = 3'd2;
  localparam logic [2:0] ADDR_CMP0  = 3'd3;
  localparam logic [2:0] ADDR_CMP1  = 3'd4;
  localparam logic [2:0] ADDR_MASK  = 3'd5;

  localparam logic [1:0] FORCE_SET = 2'b01;
  localparam logic [1:0] FORCE_CLR = 2'b10;

  typedef enum logic [1:0] {
    CAP_OFF  = 2'd0,
    CAP_BOTH = 2'd1,
    CAP_RISE = 2'd2,
    CAP_FALL = 2'd3
  } cap_mode_e;
endpackage

// File: rtl/capcmp_prescaler.sv
module capcmp_prescaler #(
  parameter int SEL_W    = 2,
  parameter int TAP_BASE = 1,
  parameter int TAP_STEP = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int NTAP  = 1 << SEL_W;
  localparam int PRE_W = TAP_BASE + TAP_STEP * (NTAP - 1);

  logic [PRE_W-1:0] pre_q;
  logic [NTAP-1:0]  tap_hit;

  always_ff @(posedge clk) begin
    if (rst || !run) pre_q <= '0;
    else             pre_q <= pre_q + 1'b1;
  end

  for (genvar i = 0; i < NTAP; i++) begin : g_tap
    localparam int LEN = TAP_BASE + TAP_STEP * i;
    assign tap_hit[i] = &pre_q[LEN-1:0];
  end

  assign tick = run & tap_hit[sel];
endmodule

// File: rtl/capcmp_trig_sync.sv
module capcmp_trig_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] sh_q;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q   <= '0;
      last_q <= 1'b0;
    end else begin
      sh_q   <= {sh_q[STAGES-2:0], pin};
      last_q <= sh_q[STAGES-1];
    end
  end

  assign rise = sh_q[STAGES-1] & ~last_q;
  assign fall = ~sh_q[STAGES-1] & last_q;
endmodule

// File: rtl/capcmp_counter.sv
module capcmp_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  output logic [W-1:0] count,
  output logic [W-1:0] next_val,
  output logic         wrap
);
  always_ff @(posedge clk) begin
    if (rst)       count <= '0;
    else if (step) count <= next_val;
  end

  assign next_val = count + 1'b1;
  assign wrap     = step & (&count);

  // R9
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    (count != $past(count)) |-> (count == $past(count) + 1'b1));
endmodule

// File: rtl/capcmp_timer.sv
module capcmp_timer
  import capcmp_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int DATA_W   = 16,
  parameter int SEL_W    = 2,
  parameter int TAP_BASE = 1,
  parameter int TAP_STEP = 2,
  parameter int SYNC_N   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              trig_in,
  output logic [CNT_W-1:0]  count,
  output logic [CNT_W-1:0]  cap0,
  output logic [CNT_W-1:0]  cap1,
  output logic              tmr_out,
  output logic              irq_cap0,
  output logic              irq_cap1,
  output logic              irq_tmr
);
  localparam int NEV = 4;

  logic [1:0]       run_q;
  logic [SEL_W-1:0] sel_q;
  cap_mode_e        cap_mode_q;
  logic [NEV-1:0]   tog_en_q;
  logic [CNT_W-1:0] cmp0_q, cmp1_q;
  logic [2:0]       mask_q;

  logic             tick, step, wrap, rise, fall;
  logic [CNT_W-1:0] next_val;
  logic             hit0, hit1, cap0_evt, cap1_evt, toggle;
  logic [NEV-1:0]   events;
  logic             ff_wr;

  capcmp_prescaler #(.SEL_W(SEL_W), .TAP_BASE(TAP_BASE), .TAP_STEP(TAP_STEP)) u_pre (
    .clk(clk), .rst(rst), .run(run_q[1]), .sel(sel_q), .tick(tick));

  capcmp_trig_sync #(.STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst(rst), .pin(trig_in), .rise(rise), .fall(fall));

  capcmp_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .step(step), .count(count), .next_val(next_val), .wrap(wrap));

  assign step     = tick & run_q[0];
  assign hit0     = step && (next_val == cmp0_q);
  assign hit1     = step && (next_val == cmp1_q);
  assign cap0_evt = rise && (cap_mode_q == CAP_BOTH || cap_mode_q == CAP_RISE);
  assign cap1_evt = fall && (cap_mode_q == CAP_BOTH || cap_mode_q == CAP_FALL);
  assign events   = {cap1_evt, cap0_evt, hit1, hit0};
  assign toggle   = ^(events & tog_en_q);
  assign ff_wr    = wr_en && (wr_addr == ADDR_FFCTL);

  // register file
  always_ff @(posedge clk) begin
    if (rst) begin
      run_q      <= '0;
      sel_q      <= '0;
      cap_mode_q <= CAP_OFF;
      tog_en_q   <= '0;
      cmp0_q     <= '0;
      cmp1_q     <= '0;
      mask_q     <= 3'b111;
    end else if (wr_en) begin
      case (wr_addr)
        ADDR_CTRL:  run_q <= wr_data[1:0];
        ADDR_MODE: begin
          sel_q      <= wr_data[SEL_W-1:0];
          cap_mode_q <= cap_mode_e'(wr_data[SEL_W+1:SEL_W]);
        end
        ADDR_FFCTL: tog_en_q <= wr_data[2+NEV-1:2];
        ADDR_CMP0:  cmp0_q   <= wr_data[CNT_W-1:0];
        ADDR_CMP1:  cmp1_q   <= wr_data[CNT_W-1:0];
        ADDR_MASK:  mask_q   <= wr_data[2:0];
        default: ;
      endcase
    end
  end

  // capture registers and interrupts
  always_ff @(posedge clk) begin
    if (rst) begin
      cap0     <= '0;
      cap1     <= '0;
      irq_cap0 <= 1'b0;
      irq_cap1 <= 1'b0;
      irq_tmr  <= 1'b0;
    end else begin
      if (cap0_evt) cap0 <= count;
      if (cap1_evt) cap1 <= count;
      irq_cap0 <= cap0_evt;
      irq_cap1 <= cap1_evt;
      irq_tmr  <= (hit0 & ~mask_q[0]) | (hit1 & ~mask_q[1]) | (wrap & ~mask_q[2]);
    end
  end

  // toggle flip-flop
  always_ff @(posedge clk) begin
    if (rst)                                 tmr_out <= 1'b0;
    else if (ff_wr && wr_data[1:0] == FORCE_CLR) tmr_out <= 1'b0;
    else if (ff_wr && wr_data[1:0] == FORCE_SET) tmr_out <= 1'b1;
    else if (toggle)                         tmr_out <= ~tmr_out;
  end

  // R2
  stop_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (run_q != 2'b11) |=> $stable(count));

  // R3
  cap0_value_chk: assert property (@(posedge clk) disable iff (rst)
    irq_cap0 |-> (cap0 == $past(count)));

  // R4
  cap_off_chk: assert property (@(posedge clk) disable iff (rst)
    (cap_mode_q == CAP_OFF) |=> (!irq_cap0 && !irq_cap1));

  // R7
  force_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == ADDR_FFCTL && wr_data[1:0] == FORCE_CLR) |=> !tmr_out);

  // R8
  mask_all_chk: assert property (@(posedge clk) disable iff (rst)
    (&mask_q) |=> !irq_tmr);
endmodule

// File: tb/tb_capcmp_timer.sv
`timescale 1ns/1ps
module tb_capcmp_timer;
  localparam int CW  = 12;
  localparam int MSK = (1 << CW) - 1;

  logic clk = 1'b0, rst = 1'b1, wr_en = 1'b0, trig_in = 1'b0;
  logic [2:0]    wr_addr = '0;
  logic [15:0]   wr_data = '0;
  logic [CW-1:0] count, cap0, cap1;
  logic tmr_out, irq_cap0, irq_cap1, irq_tmr;

  int checks = 0, fails = 0;
  bit done = 0;
  int q_tmr[$], q_out[$], q_cap0[$], q_cap1[$];
  logic last_out;
  int exp_v;

  always #5 clk = ~clk;

  capcmp_timer #(.CNT_W(CW)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .trig_in(trig_in), .count(count), .cap0(cap0), .cap1(cap1), .tmr_out(tmr_out),
    .irq_cap0(irq_cap0), .irq_cap1(irq_cap1), .irq_tmr(irq_tmr));

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst) last_out = 1'b0;
    else begin
      if (irq_tmr) begin
        checks++;
        if (q_tmr.size() == 0) begin
          fails++; $display("FAIL R8: unexpected irq_tmr at count %0d, expected none", count);
        end else begin
          exp_v = q_tmr.pop_front();
          if (exp_v >= 0 && exp_v != int'(count)) begin
            fails++; $display("FAIL R8: irq_tmr at count %0d expected %0d", count, exp_v);
          end
        end
      end
      if (irq_cap0) begin
        checks++;
        if (q_cap0.size() == 0) begin
          fails++; $display("FAIL R3: unexpected irq_cap0 value %0d, expected none", cap0);
        end else begin
          exp_v = q_cap0.pop_front();
          if (exp_v >= 0 && exp_v != int'(cap0)) begin
            fails++; $display("FAIL R3: cap0 %0d expected %0d", cap0, exp_v);
          end
        end
      end
      if (irq_cap1) begin
        checks++;
        if (q_cap1.size() == 0) begin
          fails++; $display("FAIL R3: unexpected irq_cap1 value %0d, expected none", cap1);
        end else begin
          exp_v = q_cap1.pop_front();
          if (exp_v >= 0 && exp_v != int'(cap1)) begin
            fails++; $display("FAIL R3: cap1 %0d expected %0d", cap1, exp_v);
          end
        end
      end
      if (tmr_out != last_out) begin
        checks++;
        if (q_out.size() == 0) begin
          fails++; $display("FAIL R6: unexpected tmr_out change to %0d at count %0d, expected none", tmr_out, count);
        end else begin
          exp_v = q_out.pop_front();
          if (exp_v >= 0 && exp_v != int'(count)) begin
            fails++; $display("FAIL R6: tmr_out changed at count %0d expected %0d", count, exp_v);
          end
        end
        last_out = tmr_out;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int c0, f, v, old0, old1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R11 reset state
    chk(count == 0 && tmr_out == 0, "R11 count/out", int'(count), 0);
    chk(cap0 == 0 && cap1 == 0, "R11 captures", int'(cap0), 0);
    chk(!irq_cap0 && !irq_cap1 && !irq_tmr, "R11 irqs", int'(irq_tmr), 0);
    rst = 1'b0;

    // R1 rate, code 00 then 01
    wr(3'd0, 16'h3);
    waitn(3);
    c0 = count; waitn(20);
    chk(int'(count) - c0 == 10, "R1 div2", int'(count) - c0, 10);
    wr(3'd1, 16'h1);
    waitn(8);
    c0 = count; waitn(64);
    chk(int'(count) - c0 == 8, "R1 div8", int'(count) - c0, 8);

    // R2 stop holds
    wr(3'd0, 16'h2);
    c0 = count; waitn(30);
    chk(int'(count) == c0, "R2 cnt_en off", int'(count), c0);
    wr(3'd0, 16'h1);
    waitn(30);
    chk(int'(count) == c0, "R2 prescaler off", int'(count), c0);
    wr(3'd0, 16'h0);

    // R3 capture timing and value
    f = count;
    wr(3'd1, 16'h4);
    q_cap0.push_back(f);
    @(negedge clk); trig_in = 1'b1;
    waitn(2);
    chk(!irq_cap0, "R3 no early irq", int'(irq_cap0), 0);
    waitn(1);
    chk(irq_cap0 && int'(cap0) == f, "R3 third edge capture", int'(cap0), f);
    waitn(1);
    chk(!irq_cap0, "R3 single pulse", int'(irq_cap0), 0);
    q_cap1.push_back(f);
    trig_in = 1'b0; waitn(5);
    chk(int'(cap1) == f, "R3 falling capture", int'(cap1), f);

    // R4 capture off
    wr(3'd1, 16'h0);
    old0 = cap0; old1 = cap1;
    @(negedge clk); trig_in = 1'b1; waitn(6);
    trig_in = 1'b0; waitn(6);
    chk(int'(cap0) == old0 && int'(cap1) == old1, "R4 ignored", int'(cap0), old0);

    // R7 force
    q_out.push_back(-1);
    wr(3'd2, 16'h1);
    chk(tmr_out == 1, "R7 set", int'(tmr_out), 1);
    q_out.push_back(-1);
    wr(3'd2, 16'h2);
    chk(tmr_out == 0, "R7 clear", int'(tmr_out), 0);

    // R5 capture toggles
    wr(3'd1, 16'h4);
    wr(3'd2, 16'h30);
    q_out.push_back(-1); q_cap0.push_back(f);
    @(negedge clk); trig_in = 1'b1; waitn(5);
    chk(tmr_out == 1, "R5 cap0 toggle", int'(tmr_out), 1);
    q_out.push_back(-1); q_cap1.push_back(f);
    trig_in = 1'b0; waitn(5);
    chk(tmr_out == 0, "R5 cap1 toggle", int'(tmr_out), 0);

    // R6 delayed one-shot, mask 101
    c0 = count;
    wr(3'd3, 16'((c0 + 20) & MSK));
    wr(3'd4, 16'((c0 + 30) & MSK));
    wr(3'd5, 16'h5);
    wr(3'd2, 16'h0C);
    q_out.push_back((c0 + 20) & MSK);
    q_out.push_back((c0 + 30) & MSK);
    q_tmr.push_back((c0 + 30) & MSK);
    wr(3'd1, 16'h0);
    wr(3'd0, 16'h3);
    for (int i = 0; i < 200 && int'(count) != ((c0 + 34) & MSK); i++) @(negedge clk);
    chk(tmr_out == 0 && q_out.size() == 0, "R6 delayed pulse done", q_out.size(), 0);
    chk(q_tmr.size() == 0, "R8 cmp1 irq only", q_tmr.size(), 0);
    wr(3'd0, 16'h0); wr(3'd2, 16'h0); wr(3'd5, 16'h7);

    // R5/R10 no-delay one-shot, compare set from capture
    wr(3'd1, 16'h5);
    wr(3'd2, 16'h18);
    wr(3'd5, 16'h5);
    q_out.push_back(-1); q_cap0.push_back(-1);
    wr(3'd0, 16'h3);
    waitn(10);
    trig_in = 1'b1;
    for (int i = 0; i < 20 && !irq_cap0; i++) @(negedge clk);
    v = cap0;
    chk(tmr_out == 1, "R5 pulse starts at capture", int'(tmr_out), 1);
    q_out.push_back((v + 12) & MSK);
    q_tmr.push_back((v + 12) & MSK);
    wr(3'd4, 16'((v + 12) & MSK));
    for (int i = 0; i < 400 && int'(count) != ((v + 14) & MSK); i++) @(negedge clk);
    chk(tmr_out == 0 && q_out.size() == 0, "R10 pulse ends at new compare", int'(tmr_out), 0);
    q_cap1.push_back(-1);
    trig_in = 1'b0; waitn(6);
    wr(3'd0, 16'h0); wr(3'd2, 16'h0); wr(3'd5, 16'h7);

    // R9/R10 wrap, passed compare only after wrap
    wr(3'd3, 16'd5);
    wr(3'd5, 16'h2);
    q_tmr.push_back(0);
    q_tmr.push_back(5);
    wr(3'd1, 16'h0);
    wr(3'd0, 16'h3);
    for (int i = 0; i < 9000 && q_tmr.size() != 0; i++) @(negedge clk);
    chk(q_tmr.size() == 0, "R9 R10 wrap then match", q_tmr.size(), 0);
    chk(int'(count) < 16, "R9 count wrapped", int'(count), 5);
    wr(3'd0, 16'h0); wr(3'd5, 16'h7);
    waitn(4);

    chk(q_out.size() == 0 && q_cap0.size() == 0 && q_cap1.size() == 0,
        "R6 scoreboard drained", q_out.size() + q_cap0.size() + q_cap1.size(), 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule